// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register file of a 32-bit processor core. Software addresses sixteen registers by a 4-bit index. The physical register behind an index depends on the operating mode held in the low five bits of the current status register. Index 13 is the stack pointer, index 14 is the link register and index 15 is the program counter. The exception modes have private copies of some indices. An exception handler can therefore use its own stack pointer and link register, and the fast-interrupt handler its own upper working set, without saving the interrupted context first.

The file has two combinational read ports and one synchronous write port, all translated through the current mode. It also holds the current status register, shared by every mode, and one saved status register for each of the five exception modes. An exception-entry strobe names a target mode. On that clock edge the current status is copied into the target's saved status register. The file holds 37 physical 32-bit words: 31 general registers, one current status register and five saved status registers.

Top module: `mode_bank_regfile`

## Requirements
- R1: After a synchronous active-low reset, every general register and every saved status register reads zero, and the current status register reads 0x00000013 (supervisor mode).
- R2: The mode is status bits [4:0], decoded as 0x10 user, 0x11 fast interrupt, 0x12 normal interrupt, 0x13 supervisor, 0x17 abort, 0x1B undefined and 0x1F system. Any other code behaves exactly as user mode.
- R3: Indices 0 to 7 and index 15 select the same physical register in every mode.
- R4: Indices 8 to 12 select one shared set in every mode except fast interrupt. Fast-interrupt mode has its own private registers for indices 8 to 14.
- R5: Normal-interrupt, supervisor, abort and undefined modes each have private registers for indices 13 and 14. System mode uses the user registers.
- R6: The two read ports are combinational and independent. A read of a register that is being written in the same cycle returns the old value. The new value is visible after the clock edge.
- R7: A general-register write in the same cycle as a status write goes to the bank of the mode that was in force before that edge.
- R8: The saved-status port reads and writes the saved register of the current mode. In user or system mode (and in unknown codes) it reads zero and writes to it are discarded.
- R9: On an exception-entry strobe, the current status value from before the edge is copied into the target mode's saved register. A target of user, system or an unknown code changes nothing.
- R10: If an exception entry and a saved-status write hit the same saved register in the same cycle, the exception copy wins. If they hit different saved registers, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 4 | Read port A architectural index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B architectural index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Write architectural index |
| wr_data | input | 32 | Write data |
| status_wr_en | input | 1 | Current status register write enable |
| status_wr_data | input | 32 | Current status write data |
| status_q | output | 32 | Current status register |
| saved_wr_en | input | 1 | Saved status write enable (current mode) |
| saved_wr_data | input | 32 | Saved status write data |
| saved_q | output | 32 | Saved status register of current mode |
| exc_entry | input | 1 | Exception-entry strobe |
| exc_target | input | 5 | Mode code of the exception being entered |

## Verification
Three pairs of functions can fall in the same cycle. The first is an exception entry and a saved-status write. The bench drives both strobes on one edge, once with the same target and once with different targets. It then reads the saved register of each mode to confirm which value landed where. The second is a mode change through a status write together with a general-register write; the bench reads both banks afterwards to confirm the write went to the old mode's bank. The third is a write and a read of the same register on one edge; the bench samples both read ports before and after the edge.

// File: rtl/banked_rf_pkg.sv
// Package: shared widths, mode encoding and bank layout for the banked file.
// Assumes: 31 general physical registers laid out as user(0-15), fast(16-22),
// normal irq(23-24), supervisor(25-26), abort(27-28), undefined(29-30).
package banked_rf_pkg;

    localparam int DATA_W    = 32;
    localparam int IDX_W     = 4;
    localparam int MODE_W    = 5;
    localparam int NUM_GPR   = 31;
    localparam int PHYS_W    = $clog2(NUM_GPR);
    localparam int NUM_SAVED = 5;
    localparam int SLOT_W    = $clog2(NUM_SAVED);

    localparam int FAST_BASE = 16;
    localparam int IRQ_BASE  = 23;
    localparam int SVC_BASE  = 25;
    localparam int ABT_BASE  = 27;
    localparam int UND_BASE  = 29;

    localparam logic [MODE_W-1:0] CODE_USR = 5'h10;
    localparam logic [MODE_W-1:0] CODE_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] CODE_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] CODE_SVC = 5'h13;
    localparam logic [MODE_W-1:0] CODE_ABT = 5'h17;
    localparam logic [MODE_W-1:0] CODE_UND = 5'h1B;
    localparam logic [MODE_W-1:0] CODE_SYS = 5'h1F;

    localparam logic [DATA_W-1:0] STATUS_RESET = 32'h0000_0013;

    typedef enum logic [2:0] {
        MD_USR, MD_FIQ, MD_IRQ, MD_SVC, MD_ABT, MD_UND, MD_SYS
    } mode_e;

    // Turn a 5-bit mode code into a mode; unknown codes act as user.
    function automatic mode_e decode_mode(input logic [MODE_W-1:0] code);
        case (code)
            CODE_FIQ: return MD_FIQ;
            CODE_IRQ: return MD_IRQ;
            CODE_SVC: return MD_SVC;
            CODE_ABT: return MD_ABT;
            CODE_UND: return MD_UND;
            CODE_SYS: return MD_SYS;
            default:  return MD_USR;
        endcase
    endfunction

    // True for the five modes that own a saved status register.
    function automatic logic has_saved(input mode_e m);
        return (m != MD_USR) && (m != MD_SYS);
    endfunction

    // Saved-register slot of an exception mode.
    function automatic logic [SLOT_W-1:0] saved_slot(input mode_e m);
        case (m)
            MD_IRQ:  return SLOT_W'(1);
            MD_SVC:  return SLOT_W'(2);
            MD_ABT:  return SLOT_W'(3);
            MD_UND:  return SLOT_W'(4);
            default: return SLOT_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/bank_map.sv
// Module: bank_map
// Translates an architectural index plus the current mode into a physical
// general-register number. Purely combinational; one instance per port.
// Assumes the bank layout defined in banked_rf_pkg.
module bank_map
    import banked_rf_pkg::*;
(
    input  mode_e               mode,
    input  logic [IDX_W-1:0]    idx,
    output logic [PHYS_W-1:0]   phys
);

    logic             is_upper;
    logic             is_sp_lr;
    logic [PHYS_W-1:0] sp_lr_off;

    assign is_upper  = (idx >= 4'd8) && (idx <= 4'd14);
    assign is_sp_lr  = (idx == 4'd13) || (idx == 4'd14);
    assign sp_lr_off = {{(PHYS_W-1){1'b0}}, ~idx[0]};

    // Select the physical register for this index in this mode.
    always_comb begin
        phys = PHYS_W'(idx);
        if (mode == MD_FIQ && is_upper) begin
            phys = PHYS_W'(FAST_BASE) + PHYS_W'(idx - 4'd8);
        end else if (is_sp_lr) begin
            case (mode)
                MD_IRQ:  phys = PHYS_W'(IRQ_BASE) + sp_lr_off;
                MD_SVC:  phys = PHYS_W'(SVC_BASE) + sp_lr_off;
                MD_ABT:  phys = PHYS_W'(ABT_BASE) + sp_lr_off;
                MD_UND:  phys = PHYS_W'(UND_BASE) + sp_lr_off;
                default: phys = PHYS_W'(idx);
            endcase
        end
    end

endmodule

// File: rtl/gpr_store.sv
// Module: gpr_store
// Physical general-register array with one synchronous write port and two
// combinational read ports. Read-during-write returns the old contents.
// Assumes physical indices below NUM_GPR.
module gpr_store
    import banked_rf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [PHYS_W-1:0]  w_phys,
    input  logic [DATA_W-1:0]  w_data,
    input  logic [PHYS_W-1:0]  ra_phys,
    input  logic [PHYS_W-1:0]  rb_phys,
    output logic [DATA_W-1:0]  ra_data,
    output logic [DATA_W-1:0]  rb_data
);

    logic [DATA_W-1:0] regs [NUM_GPR];

    // Clear on reset, otherwise store the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_GPR; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[w_phys] <= w_data;
        end
    end

    assign ra_data = regs[ra_phys];
    assign rb_data = regs[rb_phys];

endmodule

// File: rtl/status_bank.sv
// Module: status_bank
// Holds the shared current status register and the five saved status
// registers. Exception entry copies the pre-edge current status into the
// target's saved register and takes priority over a saved-status write.
// Assumes cur_mode is decoded from this block's own status output.
module status_bank
    import banked_rf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  mode_e              cur_mode,
    input  logic               status_we,
    input  logic [DATA_W-1:0]  status_wd,
    input  logic               saved_we,
    input  logic [DATA_W-1:0]  saved_wd,
    input  logic               exc_entry,
    input  logic [MODE_W-1:0]  exc_target,
    output logic [DATA_W-1:0]  status_q,
    output logic [DATA_W-1:0]  saved_q
);

    logic [DATA_W-1:0] status_r;
    logic [DATA_W-1:0] saved_r [NUM_SAVED];
    mode_e             tgt_mode;
    logic              exc_ok;
    logic              saved_ok;

    assign tgt_mode = decode_mode(exc_target);
    assign exc_ok   = exc_entry && has_saved(tgt_mode);
    assign saved_ok = saved_we && has_saved(cur_mode);

    // Current status register: reset to supervisor, then plain write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_r <= STATUS_RESET;
        end else if (status_we) begin
            status_r <= status_wd;
        end
    end

    for (genvar s = 0; s < NUM_SAVED; s++) begin : g_saved
        logic hit_exc;
        logic hit_wr;
        assign hit_exc = exc_ok   && (saved_slot(tgt_mode) == SLOT_W'(s));
        assign hit_wr  = saved_ok && (saved_slot(cur_mode) == SLOT_W'(s));

        // Saved slot: exception copy first, then software write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                saved_r[s] <= '0;
            end else if (hit_exc) begin
                saved_r[s] <= status_r;
            end else if (hit_wr) begin
                saved_r[s] <= saved_wd;
            end
        end
    end

    assign status_q = status_r;
    assign saved_q  = has_saved(cur_mode) ? saved_r[saved_slot(cur_mode)] : '0;

endmodule

// File: rtl/mode_bank_regfile.sv
// Module: mode_bank_regfile (top)
// Mode-banked 32-bit register file: two read ports and one write port, each
// translated through the mode held in status bits [4:0], plus current and
// saved status registers with an exception-entry copy.
// Assumes all port inputs are synchronous to clk.
module mode_bank_regfile
    import banked_rf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   rd_a_idx,
    output logic [DATA_W-1:0]  rd_a_data,
    input  logic [IDX_W-1:0]   rd_b_idx,
    output logic [DATA_W-1:0]  rd_b_data,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               status_wr_en,
    input  logic [DATA_W-1:0]  status_wr_data,
    output logic [DATA_W-1:0]  status_q,
    input  logic               saved_wr_en,
    input  logic [DATA_W-1:0]  saved_wr_data,
    output logic [DATA_W-1:0]  saved_q,
    input  logic               exc_entry,
    input  logic [MODE_W-1:0]  exc_target
);

    localparam int NUM_PORTS = 3;   // read A, read B, write

    mode_e             cur_mode;
    logic [IDX_W-1:0]  port_idx  [NUM_PORTS];
    logic [PHYS_W-1:0] port_phys [NUM_PORTS];

    assign cur_mode    = decode_mode(status_q[MODE_W-1:0]);
    assign port_idx[0] = rd_a_idx;
    assign port_idx[1] = rd_b_idx;
    assign port_idx[2] = wr_idx;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_map
        bank_map i_map (
            .mode (cur_mode),
            .idx  (port_idx[p]),
            .phys (port_phys[p])
        );
    end

    gpr_store i_gpr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .w_phys  (port_phys[2]),
        .w_data  (wr_data),
        .ra_phys (port_phys[0]),
        .rb_phys (port_phys[1]),
        .ra_data (rd_a_data),
        .rb_data (rd_b_data)
    );

    status_bank i_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_mode   (cur_mode),
        .status_we  (status_wr_en),
        .status_wd  (status_wr_data),
        .saved_we   (saved_wr_en),
        .saved_wd   (saved_wr_data),
        .exc_entry  (exc_entry),
        .exc_target (exc_target),
        .status_q   (status_q),
        .saved_q    (saved_q)
    );

endmodule

// File: rtl/mode_bank_regfile_chk.sv
// Module: mode_bank_regfile_chk
// Port-level properties of the banked register file, bound to the top.
module mode_bank_regfile_chk
    import banked_rf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   rd_a_idx,
    input  logic [DATA_W-1:0]  rd_a_data,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               status_wr_en,
    input  logic [DATA_W-1:0]  status_q,
    input  logic [DATA_W-1:0]  saved_q,
    input  logic               exc_entry,
    input  logic [MODE_W-1:0]  exc_target
);

    // R1
    reset_mode_chk: assert property (@(posedge clk)
        !rst_n |=> status_q == STATUS_RESET);

    // R8
    no_saved_in_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !has_saved(decode_mode(status_q[MODE_W-1:0])) |-> saved_q == '0);

    // R6
    write_visible_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !status_wr_en) ##1 (rd_a_idx == $past(wr_idx))
        |-> rd_a_data == $past(wr_data));

    // R9
    entry_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_entry && has_saved(decode_mode(exc_target)))
        ##1 (status_q[MODE_W-1:0] == $past(exc_target))
        |-> saved_q == $past(status_q));

    // R6
    read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !status_wr_en) ##1 ($stable(rd_a_idx) && $stable(status_q))
        |-> $stable(rd_a_data));

endmodule

bind mode_bank_regfile mode_bank_regfile_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_a_idx     (rd_a_idx),
    .rd_a_data    (rd_a_data),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data),
    .status_wr_en (status_wr_en),
    .status_q     (status_q),
    .saved_q      (saved_q),
    .exc_entry    (exc_entry),
    .exc_target   (exc_target)
);

// File: tb/test_mode_bank_regfile.sv
// Directed bench for mode_bank_regfile: one task per scenario.
module test_mode_bank_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, status_wr_en = 1'b0, saved_wr_en = 1'b0, exc_entry = 1'b0;
    logic [31:0] status_wr_data = '0, saved_wr_data = '0, status_q, saved_q;
    logic [4:0]  exc_target = '0;
    int          n_tests = 0, n_fail = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mode_bank_regfile i_mode_bank_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .status_wr_en(status_wr_en), .status_wr_data(status_wr_data), .status_q(status_q),
        .saved_wr_en(saved_wr_en), .saved_wr_data(saved_wr_data), .saved_q(saved_q),
        .exc_entry(exc_entry), .exc_target(exc_target)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_gpr(input logic [3:0] i, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_idx = i; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic set_status(input logic [31:0] d);
        @(negedge clk); status_wr_en = 1'b1; status_wr_data = d;
        @(negedge clk); status_wr_en = 1'b0;
    endtask

    task automatic wr_saved(input logic [31:0] d);
        @(negedge clk); saved_wr_en = 1'b1; saved_wr_data = d;
        @(negedge clk); saved_wr_en = 1'b0;
    endtask

    task automatic enter(input logic [4:0] m);
        @(negedge clk); exc_entry = 1'b1; exc_target = m;
        @(negedge clk); exc_entry = 1'b0;
    endtask

    task automatic expect_a(input string tag, input logic [3:0] i, input logic [31:0] exp);
        rd_a_idx = i; #2;
        chk(tag, rd_a_data, exp);
    endtask

    task automatic t_reset();
        chk("R1 status after reset", status_q, 32'h13);
        for (int i = 0; i < 16; i++) expect_a("R1 gpr after reset", 4'(i), 32'h0);
        chk("R1 saved after reset", saved_q, 32'h0);
    endtask

    task automatic t_shared_low();
        logic [4:0] codes [6] = '{5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
        set_status(32'h10);
        for (int i = 0; i < 8; i++) wr_gpr(4'(i), 32'h1000_0000 + i);
        wr_gpr(4'd15, 32'h1000_000F);
        for (int m = 0; m < 6; m++) begin
            set_status({27'h0, codes[m]});
            expect_a("R3 r0 shared", 4'd0, 32'h1000_0000);
            expect_a("R3 r7 shared", 4'd7, 32'h1000_0007);
            expect_a("R3 r15 shared", 4'd15, 32'h1000_000F);
        end
    endtask

    task automatic t_fast_bank();
        set_status(32'h10);
        for (int i = 8; i < 15; i++) wr_gpr(4'(i), 32'h2000_0000 + i);
        set_status(32'h11);
        for (int i = 8; i < 15; i++) expect_a("R4 fast bank fresh", 4'(i), 32'h0);
        for (int i = 8; i < 15; i++) wr_gpr(4'(i), 32'h3000_0000 + i);
        set_status(32'h10);
        for (int i = 8; i < 15; i++) expect_a("R4 user upper kept", 4'(i), 32'h2000_0000 + i);
        set_status(32'h11);
        for (int i = 8; i < 15; i++) expect_a("R4 fast upper kept", 4'(i), 32'h3000_0000 + i);
    endtask

    task automatic t_small_banks();
        logic [4:0] codes [4] = '{5'h12, 5'h13, 5'h17, 5'h1B};
        for (int k = 0; k < 4; k++) begin
            set_status({27'h0, codes[k]});
            wr_gpr(4'd13, 32'h4000_0000 + k * 16);
            wr_gpr(4'd14, 32'h4000_0001 + k * 16);
        end
        for (int k = 0; k < 4; k++) begin
            set_status({27'h0, codes[k]});
            expect_a("R5 private sp", 4'd13, 32'h4000_0000 + k * 16);
            expect_a("R5 private lr", 4'd14, 32'h4000_0001 + k * 16);
            expect_a("R4 r12 shared", 4'd12, 32'h2000_000C);
        end
        set_status(32'h1F);
        expect_a("R5 system sp is user", 4'd13, 32'h2000_000D);
        expect_a("R5 system lr is user", 4'd14, 32'h2000_000E);
    endtask

    task automatic t_unknown_mode();
        set_status(32'h05);
        expect_a("R2 unknown sp is user", 4'd13, 32'h2000_000D);
        chk("R2 unknown saved reads zero", saved_q, 32'h0);
        wr_gpr(4'd14, 32'h0000_5555);
        set_status(32'h10);
        expect_a("R2 unknown write hit user lr", 4'd14, 32'h0000_5555);
    endtask

    task automatic t_collision();
        set_status(32'h10);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'hCAFE_0003;
        rd_a_idx = 4'd3; rd_b_idx = 4'd3; #2;
        chk("R6 port A old during write", rd_a_data, 32'h1000_0003);
        chk("R6 port B old during write", rd_b_data, 32'h1000_0003);
        @(negedge clk); wr_en = 1'b0; #2;
        chk("R6 port A new after edge", rd_a_data, 32'hCAFE_0003);
        chk("R6 port B new after edge", rd_b_data, 32'hCAFE_0003);
        rd_b_idx = 4'd15; #2;
        chk("R6 port B independent", rd_b_data, 32'h1000_000F);
    endtask

    task automatic t_mode_order();
        @(negedge clk);
        status_wr_en = 1'b1; status_wr_data = 32'h11;
        wr_en = 1'b1; wr_idx = 4'd8; wr_data = 32'h0000_7777;
        @(negedge clk); status_wr_en = 1'b0; wr_en = 1'b0;
        chk("R7 mode switched", status_q, 32'h11);
        expect_a("R7 fast r8 untouched", 4'd8, 32'h3000_0008);
        set_status(32'h10);
        expect_a("R7 write used old mode", 4'd8, 32'h0000_7777);
    endtask

    task automatic t_saved();
        set_status(32'h13);
        wr_saved(32'h0000_5A5A); #2;
        chk("R8 svc saved write", saved_q, 32'h0000_5A5A);
        set_status(32'h10);
        wr_saved(32'h0000_1111); #2;
        chk("R8 user saved reads zero", saved_q, 32'h0);
        set_status(32'h1F); #2;
        chk("R8 system saved reads zero", saved_q, 32'h0);
        set_status(32'h13); #2;
        chk("R8 svc saved kept", saved_q, 32'h0000_5A5A);
        set_status(32'h12); #2;
        chk("R8 irq saved untouched", saved_q, 32'h0);
    endtask

    task automatic t_entry();
        logic [4:0] others [4] = '{5'h11, 5'h13, 5'h17, 5'h1B};
        logic [31:0] exp_o [4] = '{32'h0, 32'h0000_5A5A, 32'h0, 32'h0};
        set_status(32'h8000_0010);
        enter(5'h12);
        enter(5'h1F);
        enter(5'h10);
        enter(5'h03);
        set_status(32'h12); #2;
        chk("R9 irq saved copy", saved_q, 32'h8000_0010);
        for (int k = 0; k < 4; k++) begin
            set_status({27'h0, others[k]}); #2;
            chk("R9 ignored targets left slots", saved_q, exp_o[k]);
        end
        set_status(32'h12);
        @(negedge clk);
        exc_entry = 1'b1; exc_target = 5'h17;
        status_wr_en = 1'b1; status_wr_data = 32'h17;
        @(negedge clk); exc_entry = 1'b0; status_wr_en = 1'b0; #2;
        chk("R9 copy uses pre-edge status", saved_q, 32'h0000_0012);
    endtask

    task automatic t_race();
        set_status(32'h13);
        @(negedge clk);
        saved_wr_en = 1'b1; saved_wr_data = 32'h0000_DEAD;
        exc_entry = 1'b1; exc_target = 5'h13;
        @(negedge clk); saved_wr_en = 1'b0; exc_entry = 1'b0; #2;
        chk("R10 same slot entry wins", saved_q, 32'h0000_0013);
        @(negedge clk);
        saved_wr_en = 1'b1; saved_wr_data = 32'h0000_BEEF;
        exc_entry = 1'b1; exc_target = 5'h1B;
        @(negedge clk); saved_wr_en = 1'b0; exc_entry = 1'b0; #2;
        chk("R10 other slot write kept", saved_q, 32'h0000_BEEF);
        set_status(32'h1B); #2;
        chk("R10 other slot entry kept", saved_q, 32'h0000_0013);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #2;
        t_reset();
        t_shared_low();
        t_fast_bank();
        t_small_banks();
        t_unknown_mode();
        t_collision();
        t_mode_order();
        t_saved();
        t_entry();
        t_race();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule